// File: doc/BRIEF.md
# Dual-Clock Elasticity Buffer with Recentering

This block sits between a recovered receive byte clock and the local byte clock of a physical-layer receiver. Each receive-clock cycle may deliver one 10-bit entry: an 8-bit byte, its parity bit and a control bit. The entry goes into an eight-slot ring. The local side reads entries in arrival order through a show-ahead valid/ready port.

The write pointer crosses into the read domain as a Gray code through two flip-flop stages. The read side takes its fill level from that synchronized copy.

Two events make the read pointer jump to a fixed distance of four entries behind the newest synchronized write. The first is a start-delimiter (JK) pulse. The second is a line-state input that, while held high, fires a jump on every fourth read-clock edge; it is meant for the invalid-link and Idle states. Such jumps happen only between frames, so they drop or repeat Idle pairs and soak up accumulated clock drift.

A warning output rises while the fill level is still one slot away from an underrun or an overrun. The entry shown at that time is tagged.

Back-pressure rules:
- The write side has no ready signal. The line cannot be stalled, so every cycle with `wr_valid` high stores an entry.
- The read side holds its head entry for as long as `rd_ready` is low.
- A read stalled too long drives the fill level up to the warning mark.

Top module: `eb_elastic_buffer`

## Requirements
- R1: Every receive-clock edge with `wr_valid` high stores {`wr_data`, `wr_parity`, `wr_ctrl`} in the next ring slot. There is no write back-pressure.
- R2: The read port is show-ahead. A transfer occurs on a local-clock edge with `rd_valid` and `rd_ready` both high, after which the next entry is shown. Entries leave in write order with byte, parity and control bits unchanged.
- R3: `rd_valid` is low whenever the read pointer equals the synchronized write pointer, including right after reset.
- R4: With `rd_ready` low and no recentering event, the read pointer and the shown entry stay unchanged.
- R5: `jk_seen` high at a local-clock edge sets the read pointer to the synchronized write pointer minus 4. Once writes have settled, the head becomes the fourth-newest entry and the fill level is 4.
- R6: While `line_recenter` stays high, a recentering occurs on its 4th consecutive local-clock edge and on every 4th edge after that. The edge count restarts whenever the input drops. With both recentering inputs low, the head never jumps.
- R7: `rd_warn` is high while the fill level is 1 or less (so also when empty) or 7 or more. `rd_tag` equals `rd_warn` during cycles when `rd_valid` is high, and is low otherwise.
- R8: The write pointer enters the local domain as a Gray code through two flip-flop stages, so its synchronized copy changes at most one bit per local-clock edge.
- R9: The write pointer advances by exactly one per stored entry and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive byte clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_valid | input | 1 | Entry present this receive cycle |
| wr_data | input | 8 | Incoming byte |
| wr_parity | input | 1 | Incoming parity bit |
| wr_ctrl | input | 1 | Incoming control bit |
| rd_clk | input | 1 | Local byte clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_ready | input | 1 | Consumer accepts the shown entry |
| jk_seen | input | 1 | Start delimiter detected, recenter now |
| line_recenter | input | 1 | Line is invalid or Idle; recenter every fourth cycle |
| rd_valid | output | 1 | An entry is shown |
| rd_data | output | 8 | Shown byte |
| rd_parity | output | 1 | Shown parity bit |
| rd_ctrl | output | 1 | Shown control bit |
| rd_warn | output | 1 | Fill level at an early-warning mark |
| rd_tag | output | 1 | Shown entry is tagged by the warning |

## Verification
A stored entry reaches the read port two to three local-clock edges after its write edge. That delay is one write-side Gray register plus two synchronizer stages. A recentering, pop or stall changes the head on the very next local-clock edge. The streaming scoreboard therefore compares only on local-clock falling edges where a transfer is about to occur, and it lets the reader drain for many cycles before declaring the queue empty. Directed checks first wait at least six local cycles after the last write, so the synchronized pointer has settled. They then pulse or hold the recentering inputs a fixed number of edges and sample on the next falling edge.

// File: rtl/eb_pkg.sv
package eb_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              parity;
    logic              ctrl;
  } eb_entry_t;

  localparam int ENTRY_W = $bits(eb_entry_t);
endpackage

// File: rtl/eb_wr_side.sv
// Write-domain pointer: binary for addressing, registered Gray for crossing.
module eb_wr_side #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  output logic [PW-1:0] ptr_bin,
  output logic [PW-1:0] ptr_gray
);
  logic [PW-1:0] ptr_nxt;

  assign ptr_nxt = ptr_bin + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_bin  <= '0;
      ptr_gray <= '0;
    end else if (push) begin
      ptr_bin  <= ptr_nxt;
      ptr_gray <= ptr_nxt ^ (ptr_nxt >> 1);
    end
  end
endmodule

// File: rtl/eb_store.sv
// Ring storage: written on the receive clock, read combinationally by address.
module eb_store
  import eb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  eb_entry_t     wdata,
  input  logic [AW-1:0] raddr,
  output eb_entry_t     rdata
);
  eb_entry_t mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eb_gray_sync.sv
// Multi-stage synchronizer for a Gray-coded pointer, with Gray-to-binary decode.
module eb_gray_sync #(
  parameter int PW     = 4,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] gray_out,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= gray_in;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign gray_out = stage[STAGES-1];

  always_comb begin
    for (int i = 0; i < PW; i++) bin_out[i] = ^(gray_out >> i);
  end
endmodule

// File: rtl/eb_rd_ctrl.sv
// Read-domain control: read pointer, fill level, recentering timer, warning marks.
module eb_rd_ctrl #(
  parameter int PW       = 4,
  parameter int NOMINAL  = 4,
  parameter int PERIOD   = 4,
  parameter int LO_MARK  = 1,
  parameter int HI_MARK  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_ready,
  input  logic          jk_seen,
  input  logic          line_recenter,
  input  logic [PW-1:0] wsync_bin,
  output logic [PW-1:0] rd_ptr,
  output logic          rd_valid,
  output logic          rd_warn,
  output logic          recenter
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] tick_q;
  logic [PW-1:0] fill;
  logic          period_hit;

  assign period_hit = line_recenter && (tick_q == CW'(PERIOD - 1));
  assign recenter   = jk_seen || period_hit;
  assign fill       = wsync_bin - rd_ptr;
  assign rd_valid   = (fill != '0);
  assign rd_warn    = (fill <= PW'(LO_MARK)) || (fill >= PW'(HI_MARK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          tick_q <= '0;
    else if (!line_recenter || period_hit) tick_q <= '0;
    else                                 tick_q <= tick_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rd_ptr <= '0;
    else if (recenter)              rd_ptr <= wsync_bin - PW'(NOMINAL);
    else if (rd_valid && rd_ready)  rd_ptr <= rd_ptr + PW'(1);
  end
endmodule

// File: rtl/eb_elastic_buffer.sv
module eb_elastic_buffer
  import eb_pkg::*;
#(
  parameter int DEPTH           = 8,
  parameter int NOMINAL         = 4,
  parameter int RECENTER_PERIOD = 4,
  parameter int LO_MARK         = 1,
  parameter int HI_MARK         = DEPTH - 1,
  parameter int SYNC_STAGES     = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_parity,
  input  logic              wr_ctrl,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_ready,
  input  logic              jk_seen,
  input  logic              line_recenter,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_parity,
  output logic              rd_ctrl,
  output logic              rd_warn,
  output logic              rd_tag
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_ptr_bin, wr_ptr_gray;
  logic [PW-1:0] wsync_gray, wsync_bin;
  logic [PW-1:0] rd_ptr;
  logic          recenter;
  eb_entry_t     wentry, rentry;

  assign wentry = '{data: wr_data, parity: wr_parity, ctrl: wr_ctrl};

  eb_wr_side #(.PW(PW)) u_wr_side (
    .clk      (wr_clk),
    .rst_n    (wr_rst_n),
    .push     (wr_valid),
    .ptr_bin  (wr_ptr_bin),
    .ptr_gray (wr_ptr_gray)
  );

  eb_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .wr_clk (wr_clk),
    .we     (wr_valid),
    .waddr  (wr_ptr_bin[AW-1:0]),
    .wdata  (wentry),
    .raddr  (rd_ptr[AW-1:0]),
    .rdata  (rentry)
  );

  eb_gray_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
    .clk      (rd_clk),
    .rst_n    (rd_rst_n),
    .gray_in  (wr_ptr_gray),
    .gray_out (wsync_gray),
    .bin_out  (wsync_bin)
  );

  eb_rd_ctrl #(
    .PW      (PW),
    .NOMINAL (NOMINAL),
    .PERIOD  (RECENTER_PERIOD),
    .LO_MARK (LO_MARK),
    .HI_MARK (HI_MARK)
  ) u_rd_ctrl (
    .clk           (rd_clk),
    .rst_n         (rd_rst_n),
    .rd_ready      (rd_ready),
    .jk_seen       (jk_seen),
    .line_recenter (line_recenter),
    .wsync_bin     (wsync_bin),
    .rd_ptr        (rd_ptr),
    .rd_valid      (rd_valid),
    .rd_warn       (rd_warn),
    .recenter      (recenter)
  );

  assign rd_data   = rentry.data;
  assign rd_parity = rentry.parity;
  assign rd_ctrl   = rentry.ctrl;
  assign rd_tag    = rd_warn && rd_valid;
endmodule

// File: rtl/eb_checker.sv
module eb_checker #(
  parameter int PW      = 4,
  parameter int NOMINAL = 4
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          wr_valid,
  input logic [PW-1:0] wr_ptr,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          rd_ready,
  input logic          rd_valid,
  input logic          rd_warn,
  input logic          rd_tag,
  input logic          jk_seen,
  input logic          recenter,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] wsync_gray,
  input logic [PW-1:0] wsync_bin
);
  AST_WR_ADVANCE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_valid |=> wr_ptr == $past(wr_ptr) + PW'(1));                  // R9
  AST_WR_HOLD: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !wr_valid |=> $stable(wr_ptr));                                  // R9
  AST_SYNC_ONE_BIT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(wsync_gray ^ $past(wsync_gray)) <= 1);                // R8
  AST_EMPTY_NOT_VALID: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (wsync_bin == rd_ptr) |-> !rd_valid);                            // R3
  AST_STALL_HOLDS: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!rd_ready && !recenter) |=> $stable(rd_ptr));                   // R4
  AST_POP_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_valid && rd_ready && !recenter) |=> rd_ptr == $past(rd_ptr) + PW'(1)); // R2
  AST_JK_RECENTER: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    jk_seen |=> rd_ptr == $past(wsync_bin) - PW'(NOMINAL));          // R5
  AST_TAG_NEEDS_VALID: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_tag |-> (rd_valid && rd_warn));                               // R7
  AST_WARN_NEAR_EMPTY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_valid && (wsync_bin - rd_ptr) == PW'(1)) |-> rd_tag);        // R7
endmodule

bind eb_elastic_buffer eb_checker #(.PW(PW), .NOMINAL(NOMINAL)) u_eb_checker (
  .wr_clk     (wr_clk),
  .wr_rst_n   (wr_rst_n),
  .wr_valid   (wr_valid),
  .wr_ptr     (wr_ptr_bin),
  .rd_clk     (rd_clk),
  .rd_rst_n   (rd_rst_n),
  .rd_ready   (rd_ready),
  .rd_valid   (rd_valid),
  .rd_warn    (rd_warn),
  .rd_tag     (rd_tag),
  .jk_seen    (jk_seen),
  .recenter   (recenter),
  .rd_ptr     (rd_ptr),
  .wsync_gray (wsync_gray),
  .wsync_bin  (wsync_bin)
);

// File: tb/test_eb_elastic_buffer.sv
module test_eb_elastic_buffer;
  logic       wr_clk, wr_rst_n, wr_valid, wr_parity, wr_ctrl;
  logic [7:0] wr_data;
  logic       rd_clk, rd_rst_n, rd_ready, jk_seen, line_recenter;
  logic       rd_valid, rd_parity, rd_ctrl, rd_warn, rd_tag;
  logic [7:0] rd_data;

  int         compared = 0;
  int         mismatched = 0;
  int         cyc = 0;
  bit         sb_on = 0;
  bit         finished = 0;
  logic [9:0] q[$];
  logic [9:0] exp_item;

  eb_elastic_buffer i_eb_elastic_buffer (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_parity(wr_parity), .wr_ctrl(wr_ctrl), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .rd_ready(rd_ready), .jk_seen(jk_seen), .line_recenter(line_recenter),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_parity(rd_parity), .rd_ctrl(rd_ctrl),
    .rd_warn(rd_warn), .rd_tag(rd_tag)
  );

  // 125 MHz on both sides; local clock offset by 1 ns.
  initial begin wr_clk = 0; forever #4 wr_clk = ~wr_clk; end
  initial begin rd_clk = 0; #1; forever #4 rd_clk = ~rd_clk; end

  function automatic logic [9:0] mk(int i);
    logic [7:0] d;
    d = 8'(i * 37 + 5);
    return {d, ^d, (i % 3 == 0)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Driver: R1 one entry per write edge, no back-pressure; expected items queued.
  task automatic write_burst(int first, int n, int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge wr_clk);
      wr_valid = 1;
      {wr_data, wr_parity, wr_ctrl} = mk(first + k);
      if (sb_on) q.push_back(mk(first + k));
      for (int g = 0; g < gap; g++) begin
        @(negedge wr_clk);
        wr_valid = 0;
      end
    end
    @(negedge wr_clk);
    wr_valid = 0;
  endtask

  task automatic pop_one();
    @(posedge rd_clk); #2 rd_ready = 1;
    @(posedge rd_clk); #2 rd_ready = 0;
    @(negedge rd_clk);
  endtask

  // Monitor: R2 order and field integrity (R8/R9 feed this path).
  always @(negedge rd_clk) begin
    if (sb_on && rd_valid && rd_ready) begin
      exp_item = (q.size() > 0) ? q.pop_front() : 10'h3ff;
      chk("R2 order/fields", {22'd0, rd_data, rd_parity, rd_ctrl}, {22'd0, exp_item});
    end
  end

  always @(posedge wr_clk) begin
    cyc++;
    if (cyc == 20000) begin
      compared++; mismatched++;
      $display("FAIL watchdog R2 actual=%0d expected=<20000", cyc);
      summary();
    end
  end

  initial begin
    wr_rst_n = 0; rd_rst_n = 0; wr_valid = 0; wr_data = 0; wr_parity = 0; wr_ctrl = 0;
    rd_ready = 0; jk_seen = 0; line_recenter = 0;
    repeat (4) @(negedge wr_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    @(negedge rd_clk);
    chk("R3 reset valid", rd_valid, 0);
    chk("R7 reset warn (empty)", rd_warn, 1);
    chk("R7 reset tag", rd_tag, 0);

    // Stream 1: continuous writes, always-ready reader.
    sb_on = 1;
    @(posedge rd_clk); #2 rd_ready = 1;
    write_burst(0, 40, 0);
    repeat (30) @(negedge rd_clk);
    chk("R1 stream1 drained", q.size(), 0);

    // Stream 2: gappy writes, reader stalls one cycle in three (R4).
    fork
      write_burst(40, 30, 1);
      for (int k = 0; k < 150; k++) begin
        @(posedge rd_clk); #2 rd_ready = (k % 3 != 2);
      end
    join
    repeat (30) @(negedge rd_clk);
    chk("R4 stream2 drained", q.size(), 0);
    sb_on = 0;
    @(posedge rd_clk); #2 rd_ready = 0;

    // Fill with stalled reader: A0..A5.
    write_burst(100, 6, 0);
    repeat (6) @(negedge rd_clk);
    chk("R3 valid when filled", rd_valid, 1);
    chk("R4 head held", {22'd0, rd_data, rd_parity, rd_ctrl}, {22'd0, mk(100)});
    chk("R7 no warn at 6", rd_warn, 0);
    write_burst(106, 1, 0);
    repeat (6) @(negedge rd_clk);
    chk("R7 warn at 7", rd_warn, 1);
    chk("R7 tag at 7", rd_tag, 1);
    chk("R4 head still held", {22'd0, rd_data}, {24'd0, mk(100)} >> 2);

    // JK recenter: 7 written, head becomes A3.
    @(posedge rd_clk); #2 jk_seen = 1;
    @(posedge rd_clk); #2 jk_seen = 0;
    @(negedge rd_clk);
    chk("R5 head after JK", {22'd0, rd_data, rd_parity, rd_ctrl}, {22'd0, mk(103)});
    chk("R5 warn clear after JK", rd_warn, 0);

    // No event: head must not jump.
    write_burst(107, 2, 0);
    repeat (10) @(negedge rd_clk);
    chk("R6 idle inputs ignored", {22'd0, rd_data}, {24'd0, mk(103)} >> 2);

    // Periodic recenter: 9 written, expect A5 on the 4th edge.
    @(posedge rd_clk); #2 line_recenter = 1;
    repeat (3) @(posedge rd_clk);
    @(negedge rd_clk);
    chk("R6 no jump before 4th edge", {22'd0, rd_data}, {24'd0, mk(103)} >> 2);
    @(posedge rd_clk);
    @(negedge rd_clk);
    chk("R6 jump on 4th edge", {22'd0, rd_data, rd_parity, rd_ctrl}, {22'd0, mk(105)});
    line_recenter = 0;

    // Restart of edge count: 10 written, expect A6 only after 4 fresh edges.
    write_burst(109, 1, 0);
    repeat (6) @(negedge rd_clk);
    @(posedge rd_clk); #2 line_recenter = 1;
    repeat (2) @(posedge rd_clk);
    #2 line_recenter = 0;
    @(posedge rd_clk); #2 line_recenter = 1;
    repeat (3) @(posedge rd_clk);
    @(negedge rd_clk);
    chk("R6 count restarted", {22'd0, rd_data}, {24'd0, mk(105)} >> 2);
    @(posedge rd_clk);
    @(negedge rd_clk);
    line_recenter = 0;
    chk("R6 jump after restart", {22'd0, rd_data, rd_parity, rd_ctrl}, {22'd0, mk(106)});

    // Drain toward underrun: fill 4 -> 1 -> 0.
    pop_one();
    chk("R2 pop to A7", {22'd0, rd_data}, {24'd0, mk(107)} >> 2);
    chk("R7 no warn at 3", rd_warn, 0);
    pop_one();
    pop_one();
    chk("R2 pop to A9", {22'd0, rd_data}, {24'd0, mk(109)} >> 2);
    chk("R7 warn at 1", rd_warn, 1);
    chk("R7 tag at 1", rd_tag, 1);
    pop_one();
    chk("R3 empty not valid", rd_valid, 0);
    chk("R7 tag low when empty", rd_tag, 0);

    summary();
  end
endmodule